// File: doc/BRIEF.md
# Parallel Flash Program and Completion Poller

This block sits on the host side of a byte-wide parallel flash device and runs one write operation at a time for a requester. A request carries an operation type (single-byte program or whole-array erase), a target address and a data byte. The block plays out the device's unlock and command write cycles on the chip-enable, write-enable and output-enable strobes. It then reads the target location repeatedly until the status bits show that the device has finished its internal operation. The requester sees a one-cycle `op_done` pulse, or a one-cycle `op_timeout` pulse if the device never reports completion.

Completion is detected from the data the device returns, not from a ready pin. The poll mode is selected per request. In inverted-bit mode, bit 7 reads as the complement of the expected value while the device is busy. In toggle mode, bit 6 flips on every read while the device is busy. A device finishing during a status read can produce a result that looks final but does not match the expected byte. Such a read is confirmed by two further reads of the same location. A timeout counter starts when the last command write completes and uses a separate limit for each operation type, both derived from the clock rate.

Top module: `flash_prog_poller`

## Requirements
- R1: While reset is held, `fl_ce_n`, `fl_oe_n` and `fl_we_n` are 1, `fl_dq_oe` is 0, `req_ready` is 1, and `op_done` and `op_timeout` are 0.
- R2: In every write cycle, `fl_ce_n` falls at least one cycle before `fl_we_n` falls. `fl_we_n` stays low for exactly WE_CYC cycles and rises while `fl_ce_n` is still low. `fl_oe_n` stays high. `fl_addr` and `fl_dq_out` do not change while `fl_ce_n` is low.
- R3: A request with `req_op`=0 (program) produces exactly four writes, given as (address, data): (5555h, AAh), (2AAAh, 55h), (5555h, A0h), (`req_addr`, `req_data`).
- R4: A request with `req_op`=1 (chip erase) produces exactly six writes: (5555h, AAh), (2AAAh, 55h), (5555h, 80h), (5555h, AAh), (2AAAh, 55h), (5555h, 10h).
- R5: With `poll_toggle`=0 at acceptance, a read is treated as busy while its bit 7 differs from bit 7 of the expected byte. The expected byte is `req_data` for program and FFh for erase. `op_done` pulses once a read returns the whole expected byte.
- R6: With `poll_toggle`=1 at acceptance, a read is treated as busy while its bit 6 differs from bit 6 of the read before it. `op_done` pulses once two consecutive reads agree in bit 6 and the later one equals the expected byte.
- R7: A read that signals completion but does not equal the expected byte is followed by two further reads of the same address. `op_done` pulses only if both of those reads equal the expected byte; otherwise polling resumes.
- R8: If completion is not seen, `op_timeout` pulses and `op_done` does not. For a program this happens PROG_TMO_US·CLK_MHZ cycles after the last command write. For an erase the limit is the larger ERASE_TMO_US·CLK_MHZ. The error lands no later than one read cycle plus a few cycles past the limit.
- R9: From the accepting edge until the result pulse, `req_ready` is 0, requests are ignored, and no further write cycle is issued.
- R10: `op_done` and `op_timeout` are single-cycle pulses that never coincide. They are asserted in the first cycle in which `req_ready` is 1 again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle; request accepted when both high |
| req_op | input | 1 | 0 = byte program, 1 = chip erase |
| req_addr | input | AW | Target byte address (also the polled address) |
| req_data | input | 8 | Byte to program |
| poll_toggle | input | 1 | 0 = inverted bit-7 polling, 1 = bit-6 toggle polling |
| op_done | output | 1 | Operation completed (one cycle) |
| op_timeout | output | 1 | Completion not seen within limit (one cycle) |
| fl_addr | output | AW | Flash address bus |
| fl_dq_out | output | 8 | Data driven toward the flash |
| fl_dq_oe | output | 1 | Enable for the data driver |
| fl_dq_in | input | 8 | Data read from the flash |
| fl_ce_n | output | 1 | Chip enable, active low |
| fl_oe_n | output | 1 | Output enable, active low |
| fl_we_n | output | 1 | Write enable, active low |

## Verification
With the default timing, each bus cycle takes SETUP_CYC+WE_CYC+HOLD_CYC+GAP_CYC = 6 cycles. `req_ready` is due low one cycle after the accepting edge. `op_done` is due in the cycle after the edge that ends the deciding read's gap. `op_timeout` is due between the limit and the limit plus about one read cycle after the launching write-enable rise. The bench drives and samples on falling edges. It checks `req_ready` on the first falling edge after acceptance and the pulse shape on the two falling edges around the result. The timeout check measures the distance from the launch edge recorded by the flash model against that window. A flash model answers reads from the state of its own busy counter, so the time the device finishes is known exactly. The bench checks that `op_done` never comes while the model is still busy.

// File: rtl/fpp_pkg.sv
package fpp_pkg;
   typedef enum logic {OP_PROGRAM = 1'b0, OP_CHIP_ERASE = 1'b1} fpp_op_e;
   typedef enum logic [1:0] {VRD_BUSY = 2'd0, VRD_DONE = 2'd1, VRD_CONFLICT = 2'd2} fpp_verdict_e;
   localparam logic [7:0] ERASED_BYTE = 8'hFF;
endpackage

// File: rtl/fpp_cmd_table.sv
module fpp_cmd_table #(
   parameter int AW = 17
) (
   input  logic          op_erase,
   input  logic [2:0]    step,
   input  logic [AW-1:0] user_addr,
   input  logic [7:0]    user_data,
   output logic [AW-1:0] wr_addr,
   output logic [7:0]    wr_data,
   output logic          last
);
   localparam logic [AW-1:0] KEY_A = AW'(17'h05555);
   localparam logic [AW-1:0] KEY_B = AW'(17'h02AAA);

   always_comb begin
      wr_addr = KEY_A;
      wr_data = 8'hAA;
      if (op_erase) begin
         last = (step == 3'd5);
         case (step)
            3'd0: begin wr_addr = KEY_A; wr_data = 8'hAA; end
            3'd1: begin wr_addr = KEY_B; wr_data = 8'h55; end
            3'd2: begin wr_addr = KEY_A; wr_data = 8'h80; end
            3'd3: begin wr_addr = KEY_A; wr_data = 8'hAA; end
            3'd4: begin wr_addr = KEY_B; wr_data = 8'h55; end
            default: begin wr_addr = KEY_A; wr_data = 8'h10; end
         endcase
      end else begin
         last = (step == 3'd3);
         case (step)
            3'd0: begin wr_addr = KEY_A; wr_data = 8'hAA; end
            3'd1: begin wr_addr = KEY_B; wr_data = 8'h55; end
            3'd2: begin wr_addr = KEY_A; wr_data = 8'hA0; end
            default: begin wr_addr = user_addr; wr_data = user_data; end
         endcase
      end
   end
endmodule

// File: rtl/fpp_strobe_gen.sv
module fpp_strobe_gen #(
   parameter int AW        = 17,
   parameter int SETUP_CYC = 1,
   parameter int WE_CYC    = 3,
   parameter int HOLD_CYC  = 1,
   parameter int GAP_CYC   = 1,
   parameter int RD_CYC    = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic          start_wr,
   input  logic [AW-1:0] start_addr,
   input  logic [7:0]    start_data,
   input  logic [7:0]    fl_dq_in,
   output logic          fl_ce_n,
   output logic          fl_oe_n,
   output logic          fl_we_n,
   output logic [AW-1:0] fl_addr,
   output logic [7:0]    fl_dq_out,
   output logic          fl_dq_oe,
   output logic          idle,
   output logic          fin,
   output logic [7:0]    rdata
);
   localparam int M1     = (SETUP_CYC > WE_CYC) ? SETUP_CYC : WE_CYC;
   localparam int M2     = (HOLD_CYC > GAP_CYC) ? HOLD_CYC : GAP_CYC;
   localparam int M3     = (M1 > M2) ? M1 : M2;
   localparam int LEN_MX = (M3 > RD_CYC) ? M3 : RD_CYC;
   localparam int CW     = $clog2(LEN_MX + 1);

   initial begin
      AST_PARAM_LEN: assert (SETUP_CYC >= 1 && WE_CYC >= 1 && HOLD_CYC >= 1 && GAP_CYC >= 1)
         else $error("every strobe phase needs at least one cycle");
      AST_PARAM_RD: assert (RD_CYC >= 2) else $error("read strobe needs two cycles");
   end

   typedef enum logic [2:0] {PH_IDLE, PH_SETUP, PH_STROBE, PH_HOLD, PH_GAP} ph_e;
   ph_e           ph;
   logic [CW-1:0] cnt;
   logic          is_wr;
   logic          ce_act;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph        <= PH_IDLE;
         cnt       <= '0;
         is_wr     <= 1'b0;
         fl_addr   <= '0;
         fl_dq_out <= '0;
         rdata     <= '0;
      end else begin
         case (ph)
            PH_IDLE: if (start) begin
               ph        <= PH_SETUP;
               cnt       <= CW'(SETUP_CYC - 1);
               is_wr     <= start_wr;
               fl_addr   <= start_addr;
               fl_dq_out <= start_data;
            end
            PH_SETUP: if (cnt == '0) begin
               ph  <= PH_STROBE;
               cnt <= is_wr ? CW'(WE_CYC - 1) : CW'(RD_CYC - 1);
            end else cnt <= cnt - 1'b1;
            PH_STROBE: if (cnt == '0) begin
               ph  <= PH_HOLD;
               cnt <= CW'(HOLD_CYC - 1);
               if (!is_wr) rdata <= fl_dq_in;
            end else cnt <= cnt - 1'b1;
            PH_HOLD: if (cnt == '0) begin
               ph  <= PH_GAP;
               cnt <= CW'(GAP_CYC - 1);
            end else cnt <= cnt - 1'b1;
            PH_GAP: if (cnt == '0) ph <= PH_IDLE;
                    else cnt <= cnt - 1'b1;
            default: ph <= PH_IDLE;
         endcase
      end
   end

   always_comb begin
      ce_act   = (ph == PH_SETUP) || (ph == PH_STROBE) || (ph == PH_HOLD);
      fl_ce_n  = !ce_act;
      fl_we_n  = !((ph == PH_STROBE) && is_wr);
      fl_oe_n  = !((ph == PH_STROBE) && !is_wr);
      fl_dq_oe = ce_act && is_wr;
      idle     = (ph == PH_IDLE);
      fin      = (ph == PH_GAP) && (cnt == '0);
   end

   AST_WE_INSIDE_CE: assert property (@(posedge clk) disable iff (!rst_n)
      !fl_we_n |-> !fl_ce_n);                                        // R2
   AST_NO_OE_DURING_WE: assert property (@(posedge clk) disable iff (!rst_n)
      !fl_we_n |-> fl_oe_n);                                         // R2
   AST_CE_LEADS_WE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(fl_we_n) |-> $past(!fl_ce_n));                           // R2
   AST_WE_RELEASED_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fl_ce_n) |-> $past(fl_we_n));                            // R2
   AST_BUS_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!fl_ce_n && $past(!fl_ce_n)) |-> ($stable(fl_addr) && $stable(fl_dq_out))); // R2
endmodule

// File: rtl/fpp_status_judge.sv
module fpp_status_judge
   import fpp_pkg::*;
(
   input  logic         toggle_mode,
   input  logic [7:0]   rd_byte,
   input  logic [7:0]   expect_byte,
   input  logic         prev_dq6,
   input  logic         have_prev,
   output fpp_verdict_e verdict
);
   logic full_match;
   assign full_match = (rd_byte == expect_byte);

   always_comb begin
      if (toggle_mode) begin
         if (!have_prev || (rd_byte[6] != prev_dq6)) verdict = VRD_BUSY;
         else if (full_match)                        verdict = VRD_DONE;
         else                                        verdict = VRD_CONFLICT;
      end else begin
         if (full_match)                             verdict = VRD_DONE;
         else if (rd_byte[7] == expect_byte[7])      verdict = VRD_CONFLICT;
         else                                        verdict = VRD_BUSY;
      end
   end
endmodule

// File: rtl/flash_prog_poller.sv
module flash_prog_poller
   import fpp_pkg::*;
#(
   parameter int AW           = 17,
   parameter int CLK_MHZ      = 100,
   parameter int PROG_TMO_US  = 16,
   parameter int ERASE_TMO_US = 100000,
   parameter int SETUP_CYC    = 1,
   parameter int WE_CYC       = 3,
   parameter int HOLD_CYC     = 1,
   parameter int GAP_CYC      = 1,
   parameter int RD_CYC       = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_valid,
   output logic          req_ready,
   input  logic          req_op,
   input  logic [AW-1:0] req_addr,
   input  logic [7:0]    req_data,
   input  logic          poll_toggle,
   output logic          op_done,
   output logic          op_timeout,
   output logic [AW-1:0] fl_addr,
   output logic [7:0]    fl_dq_out,
   output logic          fl_dq_oe,
   input  logic [7:0]    fl_dq_in,
   output logic          fl_ce_n,
   output logic          fl_oe_n,
   output logic          fl_we_n
);
   localparam int PROG_TMO_CYC  = PROG_TMO_US * CLK_MHZ;
   localparam int ERASE_TMO_CYC = ERASE_TMO_US * CLK_MHZ;
   localparam int TMO_W         = $clog2(ERASE_TMO_CYC + 1) + 1;

   initial begin
      AST_PARAM_AW: assert (AW >= 15) else $error("address too narrow for unlock keys");
      AST_PARAM_TMO: assert (ERASE_TMO_US > PROG_TMO_US && PROG_TMO_US >= 1)
         else $error("erase limit must exceed program limit");
   end

   typedef enum logic [1:0] {ST_IDLE, ST_CMD, ST_POLL, ST_CONFIRM} st_e;
   st_e           st;
   fpp_op_e       op;
   logic [AW-1:0] tgt_addr;
   logic [7:0]    tgt_data;
   logic          tog_mode, prev_dq6, have_prev, conf_second, conf_ok;
   logic [2:0]    step;
   logic [TMO_W-1:0] tmo_cnt, tmo_lim;
   logic          tmo_hit, polling;

   logic [AW-1:0] cmd_addr;
   logic [7:0]    cmd_data, rdata, expect_byte;
   logic          cmd_last, bus_idle, bus_fin, bus_start, rd_match;
   fpp_verdict_e  verdict;

   fpp_cmd_table #(.AW(AW)) u_table (
      .op_erase(op == OP_CHIP_ERASE), .step(step), .user_addr(tgt_addr),
      .user_data(tgt_data), .wr_addr(cmd_addr), .wr_data(cmd_data), .last(cmd_last));

   fpp_strobe_gen #(.AW(AW), .SETUP_CYC(SETUP_CYC), .WE_CYC(WE_CYC),
                    .HOLD_CYC(HOLD_CYC), .GAP_CYC(GAP_CYC), .RD_CYC(RD_CYC)) u_bus (
      .clk(clk), .rst_n(rst_n), .start(bus_start), .start_wr(st == ST_CMD),
      .start_addr((st == ST_CMD) ? cmd_addr : tgt_addr), .start_data(cmd_data),
      .fl_dq_in(fl_dq_in), .fl_ce_n(fl_ce_n), .fl_oe_n(fl_oe_n), .fl_we_n(fl_we_n),
      .fl_addr(fl_addr), .fl_dq_out(fl_dq_out), .fl_dq_oe(fl_dq_oe),
      .idle(bus_idle), .fin(bus_fin), .rdata(rdata));

   fpp_status_judge u_judge (
      .toggle_mode(tog_mode), .rd_byte(rdata), .expect_byte(expect_byte),
      .prev_dq6(prev_dq6), .have_prev(have_prev), .verdict(verdict));

   always_comb begin
      expect_byte = (op == OP_CHIP_ERASE) ? ERASED_BYTE : tgt_data;
      tmo_lim     = (op == OP_CHIP_ERASE) ? TMO_W'(ERASE_TMO_CYC) : TMO_W'(PROG_TMO_CYC);
      tmo_hit     = (tmo_cnt >= tmo_lim);
      polling     = (st == ST_POLL) || (st == ST_CONFIRM);
      bus_start   = bus_idle && ((st == ST_CMD) || (polling && !tmo_hit));
      rd_match    = (rdata == expect_byte);
      req_ready   = (st == ST_IDLE);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st <= ST_IDLE; op <= OP_PROGRAM; tgt_addr <= '0; tgt_data <= '0;
         tog_mode <= 1'b0; prev_dq6 <= 1'b0; have_prev <= 1'b0;
         conf_second <= 1'b0; conf_ok <= 1'b0; step <= '0; tmo_cnt <= '0;
         op_done <= 1'b0; op_timeout <= 1'b0;
      end else begin
         op_done    <= 1'b0;
         op_timeout <= 1'b0;
         if (polling && !tmo_hit) tmo_cnt <= tmo_cnt + 1'b1;
         case (st)
            ST_IDLE: if (req_valid) begin
               st       <= ST_CMD;
               op       <= fpp_op_e'(req_op);
               tgt_addr <= req_addr;
               tgt_data <= req_data;
               tog_mode <= poll_toggle;
               step     <= '0;
            end
            ST_CMD: if (bus_fin) begin
               if (cmd_last) begin
                  st        <= ST_POLL;
                  tmo_cnt   <= '0;
                  have_prev <= 1'b0;
               end else step <= step + 1'b1;
            end
            ST_POLL: begin
               if (bus_idle && tmo_hit) begin
                  st <= ST_IDLE; op_timeout <= 1'b1;
               end else if (bus_fin) begin
                  prev_dq6  <= rdata[6];
                  have_prev <= 1'b1;
                  if (verdict == VRD_DONE) begin
                     st <= ST_IDLE; op_done <= 1'b1;
                  end else if (verdict == VRD_CONFLICT) begin
                     st <= ST_CONFIRM; conf_second <= 1'b0; conf_ok <= 1'b1;
                  end
               end
            end
            ST_CONFIRM: begin
               if (bus_idle && tmo_hit) begin
                  st <= ST_IDLE; op_timeout <= 1'b1;
               end else if (bus_fin) begin
                  prev_dq6 <= rdata[6];
                  if (!conf_second) begin
                     conf_second <= 1'b1;
                     conf_ok     <= conf_ok && rd_match;
                  end else if (conf_ok && rd_match) begin
                     st <= ST_IDLE; op_done <= 1'b1;
                  end else st <= ST_POLL;
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   AST_RESULT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(op_done && op_timeout));                                     // R10
   AST_RESULT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      (op_done || op_timeout) |=> !(op_done || op_timeout));         // R10
   AST_RESULT_WHEN_READY: assert property (@(posedge clk) disable iff (!rst_n)
      (op_done || op_timeout) |-> req_ready);                        // R10
   AST_ACCEPT_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready);                      // R9
   AST_NO_WRITE_WHILE_POLL: assert property (@(posedge clk) disable iff (!rst_n)
      polling |-> (fl_we_n && !fl_dq_oe));                           // R9
endmodule

// File: tb/flash_prog_poller_bench.sv
module flash_prog_poller_bench;
   localparam int AW = 17, MHZ = 100, PTMO_US = 2, ETMO_US = 6, WE_CYC = 3;
   localparam int PLIM = PTMO_US * MHZ, ELIM = ETMO_US * MHZ;

   logic clk = 1'b0, rst_n = 1'b0;
   always #5 clk = ~clk;

   logic req_valid = 0, req_op = 0, poll_toggle = 0;
   logic [AW-1:0] req_addr = '0;
   logic [7:0] req_data = '0;
   logic req_ready, op_done, op_timeout, fl_dq_oe, fl_ce_n, fl_oe_n, fl_we_n;
   logic [AW-1:0] fl_addr;
   logic [7:0] fl_dq_out, fl_dq_in;

   flash_prog_poller #(.AW(AW), .CLK_MHZ(MHZ), .PROG_TMO_US(PTMO_US), .ERASE_TMO_US(ETMO_US),
                       .WE_CYC(WE_CYC)) u_flash_prog_poller (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
      .req_addr(req_addr), .req_data(req_data), .poll_toggle(poll_toggle), .op_done(op_done),
      .op_timeout(op_timeout), .fl_addr(fl_addr), .fl_dq_out(fl_dq_out), .fl_dq_oe(fl_dq_oe),
      .fl_dq_in(fl_dq_in), .fl_ce_n(fl_ce_n), .fl_oe_n(fl_oe_n), .fl_we_n(fl_we_n));

   // flash model controls (written by the stimulus only)
   logic m_clr = 1, m_stuck = 0, m_gpost = 0;
   int   m_nwr = 4, m_blen = 0, m_gidx = 0;
   logic [7:0] m_exp = 8'h00;
   // flash model state (written by the model only)
   int cyc = 0;
   logic we_prev, oe_prev, ce_prev, launched, tog, gused;
   int wr_cnt, post_wr, busy_cnt, launch_cyc, rd_idx, phase_err, we_low, we_len_err;
   logic [AW-1:0] wr_a [0:7];
   logic [7:0] wr_d [0:7];
   logic [7:0] rd_val, mem_val;
   logic m_busy;
   assign m_busy = launched && (m_stuck || busy_cnt != 0);
   assign fl_dq_in = rd_val;

   always @(posedge clk) cyc <= cyc + 1;

   always @(posedge clk) begin
      if (m_clr) begin
         we_prev <= 1; oe_prev <= 1; ce_prev <= 1; launched <= 0; tog <= 0; gused <= 0;
         wr_cnt <= 0; post_wr <= 0; busy_cnt <= 0; launch_cyc <= 0; rd_idx <= 0;
         phase_err <= 0; we_low <= 0; we_len_err <= 0; rd_val <= 8'h00; mem_val <= 8'h00;
      end else begin
         we_prev <= fl_we_n; oe_prev <= fl_oe_n; ce_prev <= fl_ce_n;
         if (!fl_we_n) we_low <= we_low + 1;
         if (we_prev && !fl_we_n && (ce_prev || !fl_oe_n)) phase_err <= phase_err + 1;
         if (!we_prev && fl_we_n) begin
            we_low <= 0;
            if (fl_ce_n || !fl_dq_oe) phase_err <= phase_err + 1;
            if (we_low != WE_CYC) we_len_err <= we_len_err + 1;
            if (launched) post_wr <= post_wr + 1;
            else if (wr_cnt < 8) begin
               wr_a[wr_cnt] <= fl_addr; wr_d[wr_cnt] <= fl_dq_out;
               wr_cnt <= wr_cnt + 1;
               if (wr_cnt + 1 == m_nwr) begin
                  launched <= 1; busy_cnt <= m_blen; launch_cyc <= cyc; mem_val <= m_exp;
               end
            end
         end
         if (launched && busy_cnt > 0 && !m_stuck) busy_cnt <= busy_cnt - 1;
         if (oe_prev && !fl_oe_n && !fl_ce_n) begin
            rd_idx <= rd_idx + 1;
            if (m_busy && m_gidx == rd_idx + 1) rd_val <= m_exp ^ 8'h01;
            else if (m_busy) begin
               tog <= ~tog; rd_val <= {~m_exp[7], tog, 6'h15};
            end else if (m_gpost && !gused) begin
               gused <= 1; rd_val <= m_exp ^ 8'h01;
            end else rd_val <= mem_val;
         end
      end
   end

   int n_chk = 0, n_err = 0;
   bit finished = 0;

   task automatic check(input bit ok, input string rq, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
      end
   endtask

   function automatic logic [AW-1:0] ex_addr(input logic op, input int i, input logic [AW-1:0] a);
      if (op) return (i == 1 || i == 4) ? AW'(17'h02AAA) : AW'(17'h05555);
      if (i == 1) return AW'(17'h02AAA);
      if (i == 3) return a;
      return AW'(17'h05555);
   endfunction

   function automatic logic [7:0] ex_data(input logic op, input int i, input logic [7:0] d);
      if (op) case (i) 0, 3: return 8'hAA; 1, 4: return 8'h55; 2: return 8'h80; default: return 8'h10; endcase
      case (i) 0: return 8'hAA; 1: return 8'h55; 2: return 8'hA0; default: return d; endcase
   endfunction

   task automatic run_op(input logic op, input logic [AW-1:0] a, input logic [7:0] d, input logic tm,
                         input int blen, input logic stuck, input int gidx, input logic gpost,
                         input logic spam);
      int n, lim, res_cyc, busy_at_res, ok_seq;
      bit got_done, got_err;
      string seq_r, cmp_r;
      seq_r = op ? "R4" : "R3";
      cmp_r = (gidx != 0 || gpost) ? "R7" : (tm ? "R6" : "R5");
      lim = op ? ELIM : PLIM;
      @(negedge clk);
      m_clr = 1; m_nwr = op ? 6 : 4; m_blen = blen; m_stuck = stuck; m_gidx = gidx;
      m_gpost = gpost; m_exp = op ? 8'hFF : d;
      @(negedge clk);
      m_clr = 0;
      req_valid = 1; req_op = op; req_addr = a; req_data = d; poll_toggle = tm;
      @(negedge clk);
      check(req_ready == 0, "R9 ready after accept", int'(req_ready), 0);
      if (spam) begin req_op = ~op; req_addr = a ^ 17'h1; req_data = ~d; poll_toggle = ~tm; end
      else req_valid = 0;
      n = 0; got_done = 0; got_err = 0; res_cyc = 0; busy_at_res = 0;
      while (!got_done && !got_err && n < 4000) begin
         @(negedge clk);
         n++;
         if (op_done || op_timeout) begin
            got_done = op_done; got_err = op_timeout; res_cyc = cyc; busy_at_res = int'(m_busy);
            req_valid = 0;
         end
      end
      check(wr_cnt == m_nwr, {seq_r, " write count"}, wr_cnt, m_nwr);
      ok_seq = 1;
      for (int i = 0; i < m_nwr && i < 8; i++)
         if (wr_a[i] != ex_addr(op, i, a) || wr_d[i] != ex_data(op, i, d)) ok_seq = 0;
      check(ok_seq == 1, {seq_r, " write sequence"}, ok_seq, 1);
      check(phase_err == 0 && we_len_err == 0, "R2 strobe phasing", phase_err + we_len_err, 0);
      if (stuck) begin
         check(got_err && !got_done, "R8 timeout reported", {got_done, got_err}, 1);
         check(res_cyc - launch_cyc >= lim && res_cyc - launch_cyc <= lim + 24,
               "R8 timeout window", res_cyc - launch_cyc, lim);
      end else begin
         check(got_done && !got_err, {cmp_r, " done reported"}, {got_done, got_err}, 2);
         check(busy_at_res == 0, {cmp_r, " done after device finished"}, busy_at_res, 0);
      end
      @(negedge clk);
      check(!op_done && !op_timeout && req_ready, "R10 single pulse, ready",
            {op_done, op_timeout, req_ready}, 1);
      if (spam) repeat (12) @(negedge clk);
      check(post_wr == 0, "R9 no writes after launch", post_wr, 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_err++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4217));
      repeat (3) @(negedge clk);
      check(fl_ce_n && fl_oe_n && fl_we_n && !fl_dq_oe, "R1 strobes idle in reset",
            {fl_ce_n, fl_oe_n, fl_we_n, fl_dq_oe}, 4'b1110);
      check(req_ready && !op_done && !op_timeout, "R1 handshake in reset",
            {req_ready, op_done, op_timeout}, 3'b100);
      rst_n = 1;
      repeat (2) @(negedge clk);
      // directed corner cases
      run_op(0, 17'h1F00D, 8'h3C, 0, 40, 0, 0, 0, 0);   // R3 R5
      run_op(0, 17'h00123, 8'hC5, 1, 40, 0, 0, 0, 0);   // R6
      run_op(0, 17'h0ABCD, 8'h81, 0, 0, 0, 0, 0, 0);    // R5 zero busy
      run_op(0, 17'h0ABCE, 8'h42, 1, 0, 0, 0, 0, 0);    // R6 zero busy
      run_op(1, 17'h00010, 8'h00, 0, 450, 0, 0, 0, 0);  // R4 R5, erase beyond program limit (R8)
      run_op(1, 17'h00020, 8'h00, 1, 100, 0, 0, 0, 0);  // R4 R6
      run_op(0, 17'h03333, 8'h5A, 0, 60, 0, 2, 0, 0);   // R7 conflict rejected
      run_op(0, 17'h04444, 8'hA7, 0, 30, 0, 0, 1, 0);   // R7 conflict confirmed
      run_op(0, 17'h05555, 8'h11, 0, 0, 1, 0, 0, 0);    // R8 program timeout
      run_op(1, 17'h06666, 8'h00, 1, 0, 1, 0, 0, 0);    // R8 erase timeout
      run_op(0, 17'h07777, 8'h99, 0, 50, 0, 0, 0, 1);   // R9 requests ignored
      // random mix
      for (int k = 0; k < 16; k++) begin
         logic rop, rtm, rgp;
         logic [AW-1:0] ra;
         logic [7:0] rd;
         int rb;
         rop = (($urandom % 4) == 0);
         ra  = AW'($urandom);
         rd  = 8'($urandom);
         rtm = 1'($urandom % 2);
         rb  = rop ? 50 + int'($urandom % 400) : int'($urandom % 140);
         rgp = !rtm && (($urandom % 3) == 0);
         run_op(rop, ra, rd, rtm, rb, 0, 0, rgp, 0);
      end
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end
endmodule